// File: doc/BRIEF.md
# USART Control Word Sequencer

This block is the register front end that a processor sees when it talks to a serial port. It sits on a byte-wide bidirectional bus with an active-low chip select, active-low read and write strobes and a control/data select line. Control writes go through one address, and their meaning depends on where the block is in a sequence that starts at reset. The first control write is the mode byte. When the mode selects synchronous framing, the next one or two control writes are sync characters. After that, every control write is a command.

The block holds the decoded mode fields, the sync characters and the command bits, and drives them as registered outputs to the serial transmitter and receiver, which live outside this block. It also holds the transmit holding byte and the received byte, together with the ready and error flags. A control read returns a status byte built from those flags. A data read returns the received byte. A command with the internal-reset bit sends the sequence back to the mode stage.

Top module: `usart_cw_top`

## Requirements
- R1: After reset, tx_en, rx_en and send_brk are 0 and dtr_n and rts_n are 1. No byte is held for transmit or pending from the receiver, and every error flag is clear, so the status byte reads 0x05 while tx_shift_empty is 1.
- R2: The first control write after reset (or after an internal reset) is the mode byte. Its fields are: baud_sel = bits[1:0] (00 selects synchronous), char_len = bits[3:2], par_en = bit 4, par_even = bit 5, stop_sel = bits[7:6]. Mode outputs change at no other time.
- R3: When baud_sel is 00, the next control writes are sync characters. If mode bit 7 is 1 there is one, stored in sync_char0. If bit 7 is 0 there are two, stored in sync_char0 and then sync_char1. In asynchronous modes no sync character is taken.
- R4: Every later control write is a command, with no limit on how many. Bit 0 drives tx_en, bit 2 drives rx_en and bit 3 drives send_brk. Each new command replaces the previous bits.
- R5: dtr_n is the inverse of command bit 1 and rts_n is the inverse of command bit 5.
- R6: A command with bit 6 set returns the sequence to the mode stage. It clears every command output, the transmit and receive ready state and the error flags, and it keeps the mode and sync outputs until they are rewritten.
- R7: A command with bit 4 set clears the parity, overrun and framing flags. The other bits of that byte still take effect.
- R8: The status byte is: bit 0 = transmit holding register empty, bit 1 = received byte pending, bit 2 = holding register empty and tx_shift_empty, bit 3 = parity error, bit 4 = overrun, bit 5 = framing error, bits[7:6] = 0.
- R9: A data read returns the last received byte and clears the received-byte-pending flag.
- R10: A receive load while a byte is already pending and unread sets the overrun flag, and the new byte replaces the old one.
- R11: A data write sets thr_data and raises thr_valid. A thr_take pulse drops thr_valid.
- R12: A write strobe while cs_n is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 = control/status, 0 = data |
| dbus | inout | DW | Bidirectional processor data bus |
| thr_take | input | 1 | Transmitter has taken the holding byte |
| rx_load | input | 1 | Receiver delivers rx_byte |
| rx_byte | input | DW | Received character |
| rx_par_err | input | 1 | Parity error event |
| rx_frm_err | input | 1 | Framing error event |
| tx_shift_empty | input | 1 | Transmit shifter idle |
| baud_sel | output | 2 | Mode baud factor field |
| char_len | output | 2 | Mode character length field |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| stop_sel | output | 2 | Stop bits / sync count field |
| sync_char0 | output | DW | First sync character |
| sync_char1 | output | DW | Second sync character |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| send_brk | output | 1 | Force break on the line |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| thr_data | output | DW | Transmit holding byte |
| thr_valid | output | 1 | Holding byte waiting for the transmitter |

## Verification
The bench walks the sequencer through its branches. In the two-sync and one-sync branches, a design that miscounted would treat a sync byte as a command or a command as a sync byte, and tx_en would then come out wrong. After an internal reset, the bench checks that the next control write is taken as a mode byte and not as a command, and that the earlier sync characters are still held. Two receive loads with no read between them must raise overrun and keep only the later byte. An error-reset byte that also carries enable bits must clear the flags and still apply those enables. A write with chip select high must leave every output as it was.

// File: rtl/usart_cw_pkg.sv
package usart_cw_pkg;

  typedef enum logic [1:0] {
    SEQ_MODE  = 2'd0,
    SEQ_SYNC1 = 2'd1,
    SEQ_SYNC2 = 2'd2,
    SEQ_CMD   = 2'd3
  } seq_t;

  typedef struct packed {
    logic [1:0] stop;
    logic       par_even;
    logic       par_en;
    logic [1:0] clen;
    logic [1:0] baud;
  } mode_t;

  localparam int CB_TXEN = 0;
  localparam int CB_DTR  = 1;
  localparam int CB_RXEN = 2;
  localparam int CB_BRK  = 3;
  localparam int CB_ECLR = 4;
  localparam int CB_RTS  = 5;
  localparam int CB_IRST = 6;

  localparam int SB_TXRDY = 0;
  localparam int SB_RXRDY = 1;
  localparam int SB_TXEMP = 2;
  localparam int SB_PE    = 3;
  localparam int SB_OE    = 4;
  localparam int SB_FE    = 5;

endpackage

// File: rtl/usart_bus_if.sv
module usart_bus_if #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          cd,
  input  logic [DW-1:0] din,
  output logic          wr_ctl_p,
  output logic          wr_dat_p,
  output logic          rd_dat_p,
  output logic [DW-1:0] wdata,
  output logic          drv_en
);

  logic wr_act, rd_act, wr_q, rd_q;

  assign wr_act = !cs_n && !wr_n && rd_n;
  assign rd_act = !cs_n && !rd_n && wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      wr_ctl_p <= 1'b0;
      wr_dat_p <= 1'b0;
      rd_dat_p <= 1'b0;
      wdata    <= '0;
      drv_en   <= 1'b0;
    end else begin
      wr_q     <= wr_act;
      rd_q     <= rd_act;
      wr_ctl_p <= wr_act && !wr_q && cd;
      wr_dat_p <= wr_act && !wr_q && !cd;
      rd_dat_p <= rd_act && !rd_q && !cd;
      wdata    <= din;
      drv_en   <= rd_act;
    end
  end

endmodule

// File: rtl/usart_cw_seq.sv
module usart_cw_seq
  import usart_cw_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NSYNC = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_ctl_p,
  input  logic [DW-1:0]             wdata,
  output seq_t                      seq,
  output mode_t                     mode,
  output logic [NSYNC-1:0][DW-1:0]  sync_q,
  output logic                      tx_en,
  output logic                      rx_en,
  output logic                      send_brk,
  output logic                      dtr_n,
  output logic                      rts_n,
  output logic                      err_clr_p,
  output logic                      irst_p
);

  localparam int MODE_W = $bits(mode_t);

  logic [NSYNC-1:0] sync_we;
  logic [MODE_W-1:0] cw;

  assign cw = wdata[MODE_W-1:0];

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    assign sync_we[g] = wr_ctl_p && (seq == ((g == 0) ? SEQ_SYNC1 : SEQ_SYNC2));
    always_ff @(posedge clk) begin
      if (rst)              sync_q[g] <= '0;
      else if (sync_we[g])  sync_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq       <= SEQ_MODE;
      mode      <= '0;
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      send_brk  <= 1'b0;
      dtr_n     <= 1'b1;
      rts_n     <= 1'b1;
      err_clr_p <= 1'b0;
      irst_p    <= 1'b0;
    end else begin
      err_clr_p <= 1'b0;
      irst_p    <= 1'b0;
      if (wr_ctl_p) begin
        unique case (seq)
          SEQ_MODE: begin
            mode <= mode_t'(cw);
            seq  <= (cw[1:0] == 2'b00) ? SEQ_SYNC1 : SEQ_CMD;
          end
          SEQ_SYNC1: seq <= mode.stop[1] ? SEQ_CMD : SEQ_SYNC2;
          SEQ_SYNC2: seq <= SEQ_CMD;
          SEQ_CMD: begin
            if (cw[CB_IRST]) begin
              seq      <= SEQ_MODE;
              tx_en    <= 1'b0;
              rx_en    <= 1'b0;
              send_brk <= 1'b0;
              dtr_n    <= 1'b1;
              rts_n    <= 1'b1;
              irst_p   <= 1'b1;
            end else begin
              tx_en     <= cw[CB_TXEN];
              rx_en     <= cw[CB_RXEN];
              send_brk  <= cw[CB_BRK];
              dtr_n     <= !cw[CB_DTR];
              rts_n     <= !cw[CB_RTS];
              err_clr_p <= cw[CB_ECLR];
            end
          end
          default: seq <= SEQ_MODE;
        endcase
      end
    end
  end

endmodule

// File: rtl/usart_stat.sv
module usart_stat
  import usart_cw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irst_p,
  input  logic          err_clr_p,
  input  logic          rd_dat_p,
  input  logic          wr_dat_p,
  input  logic [DW-1:0] wdata,
  input  logic          cd,
  input  logic          thr_take,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          tx_shift_empty,
  output logic [DW-1:0] thr_data,
  output logic          thr_valid,
  output logic          rx_rdy,
  output logic          oe_flag,
  output logic [DW-1:0] rdata
);

  logic          clr;
  logic          pe_flag, fe_flag;
  logic [DW-1:0] rbr;
  logic [DW-1:0] status;

  assign clr = rst || irst_p;

  always_ff @(posedge clk) begin
    if (rst) thr_data <= '0;
    else if (wr_dat_p) thr_data <= wdata;
  end

  always_ff @(posedge clk) begin
    if (clr)           thr_valid <= 1'b0;
    else if (wr_dat_p) thr_valid <= 1'b1;
    else if (thr_take) thr_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) rbr <= '0;
    else if (rx_load) rbr <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (clr)           rx_rdy <= 1'b0;
    else if (rx_load)  rx_rdy <= 1'b1;
    else if (rd_dat_p) rx_rdy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      pe_flag <= 1'b0;
      oe_flag <= 1'b0;
      fe_flag <= 1'b0;
    end else begin
      if (err_clr_p) begin
        pe_flag <= 1'b0;
        oe_flag <= 1'b0;
        fe_flag <= 1'b0;
      end
      if (rx_par_err) pe_flag <= 1'b1;
      if (rx_frm_err) fe_flag <= 1'b1;
      if (rx_load && rx_rdy && !rd_dat_p) oe_flag <= 1'b1;
    end
  end

  always_comb begin
    status           = '0;
    status[SB_TXRDY] = !thr_valid;
    status[SB_RXRDY] = rx_rdy;
    status[SB_TXEMP] = !thr_valid && tx_shift_empty;
    status[SB_PE]    = pe_flag;
    status[SB_OE]    = oe_flag;
    status[SB_FE]    = fe_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= cd ? status : rbr;
  end

endmodule

// File: rtl/usart_cw_top.sv
module usart_cw_top
  import usart_cw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          cd,
  inout  wire  [DW-1:0] dbus,
  input  logic          thr_take,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          tx_shift_empty,
  output logic [1:0]    baud_sel,
  output logic [1:0]    char_len,
  output logic          par_en,
  output logic          par_even,
  output logic [1:0]    stop_sel,
  output logic [DW-1:0] sync_char0,
  output logic [DW-1:0] sync_char1,
  output logic          tx_en,
  output logic          rx_en,
  output logic          send_brk,
  output logic          dtr_n,
  output logic          rts_n,
  output logic [DW-1:0] thr_data,
  output logic          thr_valid
);

  localparam int NSYNC = 2;

  logic                     wr_ctl_p, wr_dat_p, rd_dat_p, drv_en;
  logic [DW-1:0]            wdata, rdata;
  logic                     err_clr_p, irst_p, rx_rdy, oe_flag;
  seq_t                     seq;
  mode_t                    mode;
  logic [NSYNC-1:0][DW-1:0] sync_q;

  assign dbus = drv_en ? rdata : 'z;

  usart_bus_if #(.DW(DW)) u_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .din(dbus), .wr_ctl_p(wr_ctl_p), .wr_dat_p(wr_dat_p), .rd_dat_p(rd_dat_p),
    .wdata(wdata), .drv_en(drv_en)
  );

  usart_cw_seq #(.DW(DW), .NSYNC(NSYNC)) u_seq (
    .clk(clk), .rst(rst), .wr_ctl_p(wr_ctl_p), .wdata(wdata), .seq(seq),
    .mode(mode), .sync_q(sync_q), .tx_en(tx_en), .rx_en(rx_en),
    .send_brk(send_brk), .dtr_n(dtr_n), .rts_n(rts_n),
    .err_clr_p(err_clr_p), .irst_p(irst_p)
  );

  usart_stat #(.DW(DW)) u_stat (
    .clk(clk), .rst(rst), .irst_p(irst_p), .err_clr_p(err_clr_p),
    .rd_dat_p(rd_dat_p), .wr_dat_p(wr_dat_p), .wdata(wdata), .cd(cd),
    .thr_take(thr_take), .rx_load(rx_load), .rx_byte(rx_byte),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .tx_shift_empty(tx_shift_empty), .thr_data(thr_data),
    .thr_valid(thr_valid), .rx_rdy(rx_rdy), .oe_flag(oe_flag), .rdata(rdata)
  );

  assign baud_sel   = mode.baud;
  assign char_len   = mode.clen;
  assign par_en     = mode.par_en;
  assign par_even   = mode.par_even;
  assign stop_sel   = mode.stop;
  assign sync_char0 = sync_q[0];
  assign sync_char1 = sync_q[1];

endmodule

// File: rtl/usart_cw_chk.sv
module usart_cw_chk
  import usart_cw_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  wr_ctl_p,
  input logic  wr_dat_p,
  input logic  rd_dat_p,
  input logic  irst_p,
  input logic  rx_load,
  input logic  rx_rdy,
  input logic  oe_flag,
  input logic  thr_valid,
  input logic  tx_en,
  input logic  rx_en,
  input logic  send_brk,
  input logic  dtr_n,
  input logic  rts_n,
  input seq_t  seq,
  input mode_t mode
);

  logic rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      AST_RESET_QUIET: assert (!tx_en && !rx_en && !send_brk && dtr_n && rts_n && !rx_rdy && !thr_valid); // R1
    end
  end

  AST_MODE_ONLY_FIRST: assert property (@(posedge clk) disable iff (rst) !$stable(mode) |-> $past(seq) == SEQ_MODE); // R2

  AST_SYNC2_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst) seq == SEQ_SYNC2 |-> (mode.baud == 2'b00 && !mode.stop[1])); // R3

  AST_DTR_BY_CMD: assert property (@(posedge clk) disable iff (rst) !$stable(dtr_n) |-> $past(wr_ctl_p)); // R5

  AST_RXRDY_DROP: assert property (@(posedge clk) disable iff (rst) (rd_dat_p && !rx_load) |=> !rx_rdy); // R9

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst) (rx_load && rx_rdy && !rd_dat_p && !irst_p) |=> oe_flag); // R10

  AST_THR_LOAD: assert property (@(posedge clk) disable iff (rst) (wr_dat_p && !irst_p) |=> thr_valid); // R11

endmodule

bind usart_cw_top usart_cw_chk u_chk (
  .clk(clk), .rst(rst), .wr_ctl_p(wr_ctl_p), .wr_dat_p(wr_dat_p),
  .rd_dat_p(rd_dat_p), .irst_p(irst_p), .rx_load(rx_load), .rx_rdy(rx_rdy),
  .oe_flag(oe_flag), .thr_valid(thr_valid), .tx_en(tx_en), .rx_en(rx_en),
  .send_brk(send_brk), .dtr_n(dtr_n), .rts_n(rts_n), .seq(seq), .mode(mode)
);

// File: tb/usart_cw_top_tb.sv
module usart_cw_top_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
  logic          tb_drv = 1'b0;
  logic [DW-1:0] tb_d = '0;
  wire  [DW-1:0] dbus;
  logic          thr_take = 1'b0, rx_load = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic          rx_par_err = 1'b0, rx_frm_err = 1'b0, tx_shift_empty = 1'b1;
  logic [1:0]    baud_sel, char_len, stop_sel;
  logic          par_en, par_even;
  logic [DW-1:0] sync_char0, sync_char1, thr_data;
  logic          tx_en, rx_en, send_brk, dtr_n, rts_n, thr_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  assign dbus = tb_drv ? tb_d : 'z;

  always #4 clk = !clk;

  usart_cw_top #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
    .dbus(dbus), .thr_take(thr_take), .rx_load(rx_load), .rx_byte(rx_byte),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .tx_shift_empty(tx_shift_empty), .baud_sel(baud_sel), .char_len(char_len),
    .par_en(par_en), .par_even(par_even), .stop_sel(stop_sel),
    .sync_char0(sync_char0), .sync_char1(sync_char1), .tx_en(tx_en),
    .rx_en(rx_en), .send_brk(send_brk), .dtr_n(dtr_n), .rts_n(rts_n),
    .thr_data(thr_data), .thr_valid(thr_valid)
  );

  function automatic logic [7:0] exp_status(input logic thrv, input logic rxr,
      input logic txse, input logic pe, input logic oe, input logic fe);
    return {2'b00, fe, oe, pe, (!thrv && txse), rxr, !thrv};
  endfunction

  function automatic logic [4:0] exp_cmd(input logic [7:0] c);
    return {c[0], c[2], c[3], !c[1], !c[5]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic c, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs_n = !sel; cd = c; wr_n = 1'b0; tb_drv = 1'b1; tb_d = d;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; tb_drv = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_rd(input logic c, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; cd = c; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    d = dbus;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rx_deliver(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rx_load = 1'b1; rx_byte = b; rx_par_err = pe; rx_frm_err = fe;
    @(negedge clk);
    rx_load = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] mode_out();
    return {stop_sel, par_even, par_en, char_len, baud_sel};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] e_s0, e_s1;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 cmd outputs", {27'd0, tx_en, rx_en, send_brk, dtr_n, rts_n}, {27'd0, 5'b00011});
    bus_rd(1'b1, rd);
    chk("R1 status", rd, 8'h05);

    // R12 deselected write ignored
    bus_wr(1'b1, 8'h4E, 1'b0);
    chk("R12 mode untouched", mode_out(), 8'h00);
    bus_wr(1'b0, 8'h99, 1'b0);
    chk("R12 thr untouched", thr_valid, 1'b0);

    // R2 mode byte
    bus_wr(1'b1, 8'h7E);
    chk("R2 mode fields", mode_out(), 8'h7E);
    // R4 R5 commands
    bus_wr(1'b1, 8'h27);
    chk("R4 R5 cmd 27", {27'd0, tx_en, rx_en, send_brk, dtr_n, rts_n}, {27'd0, exp_cmd(8'h27)});
    chk("R2 mode held after cmd", mode_out(), 8'h7E);
    bus_wr(1'b1, 8'h08);
    chk("R4 cmd brk", {27'd0, tx_en, rx_en, send_brk, dtr_n, rts_n}, {27'd0, 5'b00111});

    // R10 R8 overrun and errors
    rx_deliver(8'h3C, 1'b1, 1'b0);
    rx_deliver(8'hC3, 1'b0, 1'b1);
    bus_rd(1'b1, rd);
    chk("R8 R10 status errs", rd, exp_status(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1));
    bus_rd(1'b0, rd);
    chk("R9 R10 data read", rd, 8'hC3);
    bus_rd(1'b1, rd);
    chk("R9 rxrdy cleared", rd[1], 1'b0);

    // R7 error reset with enables
    bus_wr(1'b1, 8'h13);
    bus_rd(1'b1, rd);
    chk("R7 errors cleared", rd, 8'h05);
    chk("R7 other bits", {27'd0, tx_en, rx_en, send_brk, dtr_n, rts_n}, {27'd0, exp_cmd(8'h13)});

    // R11 holding register
    bus_wr(1'b0, 8'hA5);
    chk("R11 thr data", {thr_valid, thr_data}, {1'b1, 8'hA5});
    bus_rd(1'b1, rd);
    chk("R8 tx busy status", rd, exp_status(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    @(negedge clk); thr_take = 1'b1; @(negedge clk); thr_take = 1'b0; @(negedge clk);
    chk("R11 thr taken", thr_valid, 1'b0);

    // R6 internal reset
    bus_wr(1'b0, 8'h11);
    rx_deliver(8'h55, 1'b1, 1'b0);
    bus_wr(1'b1, 8'h40);
    chk("R6 cmd cleared", {27'd0, tx_en, rx_en, send_brk, dtr_n, rts_n}, {27'd0, 5'b00011});
    chk("R6 mode kept", mode_out(), 8'h7E);
    bus_rd(1'b1, rd);
    chk("R6 status cleared", rd, 8'h05);

    // R3 two sync characters
    bus_wr(1'b1, 8'h00);
    chk("R2 mode after irst", mode_out(), 8'h00);
    bus_wr(1'b1, 8'h16);
    chk("R3 no cmd yet", tx_en, 1'b0);
    bus_wr(1'b1, 8'h17);
    chk("R3 sync pair", {sync_char0, sync_char1}, 16'h1617);
    bus_wr(1'b1, 8'h05);
    chk("R4 cmd after sync", {tx_en, rx_en}, 2'b11);
    chk("R3 sync held", {sync_char0, sync_char1}, 16'h1617);

    // R3 single sync character
    bus_wr(1'b1, 8'h40);
    bus_wr(1'b1, 8'h80);
    bus_wr(1'b1, 8'h33);
    bus_wr(1'b1, 8'h01);
    chk("R3 single sync", {sync_char0, sync_char1}, 16'h3317);
    chk("R4 cmd after one sync", tx_en, 1'b1);

    // random sequences
    e_s0 = 8'h33; e_s1 = 8'h17;
    for (int i = 0; i < 30; i++) begin
      logic [7:0] m, c, s0, s1;
      m  = 8'($urandom);
      c  = 8'($urandom) & 8'hBF;
      s0 = 8'($urandom);
      s1 = 8'($urandom);
      if (i % 3 == 0) m[1:0] = 2'b00;
      bus_wr(1'b1, 8'h40);
      bus_wr(1'b1, m);
      if (m[1:0] == 2'b00) begin
        bus_wr(1'b1, s0);
        e_s0 = s0;
        if (!m[7]) begin
          bus_wr(1'b1, s1);
          e_s1 = s1;
        end
      end
      bus_wr(1'b1, c);
      chk("R2 random mode", mode_out(), m);
      chk("R3 random sync", {sync_char0, sync_char1}, {e_s0, e_s1});
      chk("R4 R5 random cmd", {27'd0, tx_en, rx_en, send_brk, dtr_n, rts_n}, {27'd0, exp_cmd(c)});
    end

    summary();
  end

endmodule